// File: doc/BRIEF.md
# JTAG Test Access Port with Fixed Instruction Set

This block is a boundary-scan test access port of the IEEE 1149.1 kind. A 16-state controller advances on each rising edge of the test clock under the mode-select input. A 4-bit instruction register then selects one of three data paths between the serial input and the serial output. The three paths are a one-stage bypass, a 32-bit identification word, and a boundary chain whose length is a parameter. Every instruction code is fixed. Codes that have no function are treated as bypass.

A chip-level wrapper uses two control outputs. One tells the pad ring to drive the boundary hold values onto the device outputs. The other tells the pads to float the device outputs. The serial output comes with an enable that is high only while bits are being shifted. Both change on the falling edge of the test clock, so the tester can sample them on the next rising edge.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low, the controller is held in Test-Logic-Reset and the active instruction is identification (code 0010). In the same condition `ext_drive`, `hiz_force`, `tdo_oe` and `bsc_out` are all low.
- R2: When `tms` is high on five consecutive rising edges of `tck`, the controller reaches Test-Logic-Reset from any state. The next rising edge that passes through that state restores the identification instruction.
- R3: Capture-IR loads the fixed pattern 0001 into the instruction shifter. Instruction bits shift least significant bit first. A new instruction takes effect only on the edge that leaves Update-IR.
- R4: Code 1111 selects a one-stage bypass register. This register captures 0, so a DR scan first returns 0 and then returns each `tdi` bit one cycle late.
- R5: Every code from 0100 to 1110 behaves exactly like code 1111.
- R6: Code 0010 selects a 32-bit identification word, shifted out least significant bit first. Its layout is revision in bits 31:28 (default 0), device number in bits 27:12 (default 0x0312), vendor code 0x033 in bits 11:1, and 1 in bit 0.
- R7: Code 0001 (sample/preload) puts the boundary chain on the scan path. Capture-DR loads `bsc_in`, and cell 0 is the first bit out. Bits from `tdi` enter at the highest cell. Update-DR copies the chain into `bsc_out`. `ext_drive` stays low.
- R8: Code 0000 (external test) uses the same boundary chain path as code 0001, and `ext_drive` is high while this instruction is active.
- R9: Code 0011 selects the one-stage bypass path, sets `hiz_force` high and keeps `ext_drive` low.
- R10: `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR. `tdo` and `tdo_oe` change only on falling edges of `tck`.
- R11: An Update-DR under any instruction that does not select the boundary chain leaves `bsc_out` unchanged.
- R12: Pause-DR and Exit2-DR hold the chain contents, so a scan split by a pause returns the same bits as a scan done in one pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsc_in | input | CELLS | Device input values captured by the boundary chain |
| bsc_out | output | CELLS | Boundary hold values for the device outputs |
| ext_drive | output | 1 | Pads drive `bsc_out` instead of core data |
| hiz_force | output | 1 | Pads float the device outputs |

## Verification
The bench applies random reserved codes. A decoder that lets any of them fall through to the boundary chain or the identification word would return the wrong scan length or the wrong data. It splits an identification scan around Pause-DR. A shifter that kept moving in Pause or Exit2 would return misaligned bits. It also runs an Update-DR under bypass after a preload, which catches a hold stage that updates without regard to the instruction. Every tick compares `tdo` just after the rising edge with its value just before that edge. An output stage clocked on the wrong edge shows up at once. The five-high `tms` escape is exercised from a non-default instruction, which exposes a reset path that forgets to restore identification.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int unsigned IR_W = 4;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDENT  = 4'b0010;
    localparam logic [IR_W-1:0] OP_FLOAT  = 4'b0011;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE_PATTERN = 4'b0001;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDENT,
        PATH_BOUNDARY
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     ext_drive;
        logic     hiz;
    } insn_ctl_t;

    function automatic insn_ctl_t decode_op(input logic [IR_W-1:0] op);
        insn_ctl_t c;
        c = '{path: PATH_BYPASS, ext_drive: 1'b0, hiz: 1'b0};
        case (op)
            OP_EXTEST: begin c.path = PATH_BOUNDARY; c.ext_drive = 1'b1; end
            OP_SAMPLE: c.path = PATH_BOUNDARY;
            OP_IDENT:  c.path = PATH_IDENT;
            OP_FLOAT:  c.hiz = 1'b1;
            default:   c.path = PATH_BYPASS;
        endcase
        return c;
    endfunction

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   n = m ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   n = m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: n = m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: n = m ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: n = m ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: n = m ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   n = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   n = m ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   n = m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: n = m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: n = m ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: n = m ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: n = m ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   n = m ? ST_SEL_DR   : ST_IDLE;
            default:     n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);
    localparam int unsigned ESCAPE_EDGES = 5;
    localparam int unsigned RUN_W = $clog2(ESCAPE_EDGES + 1);

    typedef struct packed {
        tap_state_e       state;
        logic [RUN_W-1:0] tms_run;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        fsm_d.state = tap_next(fsm_q.state, tms);
        if (!tms)
            fsm_d.tms_run = '0;
        else if (fsm_q.tms_run < RUN_W'(ESCAPE_EDGES))
            fsm_d.tms_run = fsm_q.tms_run + 1'b1;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            fsm_q <= '{state: ST_RESET, tms_run: '0};
        else
            fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.state;

    // five consecutive high samples of tms always land in Test-Logic-Reset
    assert_tms_escape_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (fsm_q.tms_run >= RUN_W'(ESCAPE_EDGES - 1) && tms) |=> (fsm_q.state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state_i,
    input  logic            tdi,
    output logic [IR_W-1:0] active_o,
    output logic            serial_o
);
    typedef struct packed {
        logic [IR_W-1:0] shifter;
        logic [IR_W-1:0] active;
    } ir_regs_t;

    ir_regs_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        case (state_i)
            ST_RESET:    ir_d.active  = OP_IDENT;
            ST_CAP_IR:   ir_d.shifter = IR_CAPTURE_PATTERN;
            ST_SHIFT_IR: ir_d.shifter = {tdi, ir_q.shifter[IR_W-1:1]};
            ST_UPD_IR:   ir_d.active  = ir_q.shifter;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            ir_q <= '{shifter: IR_CAPTURE_PATTERN, active: OP_IDENT};
        else
            ir_q <= ir_d;
    end

    assign active_o = ir_q.active;
    assign serial_o = ir_q.shifter[0];

    assert_capture_pattern_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_IR) |=> (ir_q.shifter == IR_CAPTURE_PATTERN));

    assert_active_only_on_update_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i != ST_UPD_IR && state_i != ST_RESET) |=> $stable(ir_q.active));

    assert_reset_restores_ident_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_RESET) |=> (ir_q.active == OP_IDENT));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter int unsigned CELLS   = 8,
    parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_e       state_i,
    input  dr_path_e         path_i,
    input  logic             tdi,
    input  logic [CELLS-1:0] bsc_in,
    output logic [CELLS-1:0] hold_o,
    output logic             serial_o
);
    localparam int unsigned ID_W = 32;

    typedef struct packed {
        logic             byp;
        logic [ID_W-1:0]  ident;
        logic [CELLS-1:0] chain;
        logic [CELLS-1:0] hold;
    } dr_regs_t;

    dr_regs_t dr_d, dr_q;

    always_comb begin
        dr_d = dr_q;
        case (state_i)
            ST_CAP_DR: begin
                dr_d.byp = 1'b0;
                if (path_i == PATH_IDENT)    dr_d.ident = ID_WORD;
                if (path_i == PATH_BOUNDARY) dr_d.chain = bsc_in;
            end
            ST_SHIFT_DR: begin
                case (path_i)
                    PATH_IDENT:    dr_d.ident = {tdi, dr_q.ident[ID_W-1:1]};
                    PATH_BOUNDARY: dr_d.chain = {tdi, dr_q.chain[CELLS-1:1]};
                    default:       dr_d.byp   = tdi;
                endcase
            end
            ST_UPD_DR: begin
                if (path_i == PATH_BOUNDARY) dr_d.hold = dr_q.chain;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            dr_q <= '{byp: 1'b0, ident: ID_WORD, chain: '0, hold: '0};
        else
            dr_q <= dr_d;
    end

    always_comb begin
        case (path_i)
            PATH_IDENT:    serial_o = dr_q.ident[0];
            PATH_BOUNDARY: serial_o = dr_q.chain[0];
            default:       serial_o = dr_q.byp;
        endcase
    end

    assign hold_o = dr_q.hold;

    assert_bypass_captures_zero_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR) |=> (dr_q.byp == 1'b0));

    assert_ident_capture_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR && path_i == PATH_IDENT) |=> (dr_q.ident == ID_WORD));

    assert_hold_only_on_update_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i != ST_UPD_DR || path_i != PATH_BOUNDARY) |=> $stable(dr_q.hold));

    assert_pause_keeps_chain_R12: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_PAUSE_DR || state_i == ST_EXIT2_DR) |=> ($stable(dr_q.chain) && $stable(dr_q.ident)));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int unsigned CELLS    = 8,
    parameter logic [3:0]  REVISION = 4'h0,
    parameter logic [15:0] DEV_ID   = 16'h0312,
    parameter logic [10:0] VENDOR   = 11'h033
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [CELLS-1:0] bsc_in,
    output logic [CELLS-1:0] bsc_out,
    output logic             ext_drive,
    output logic             hiz_force
);
    localparam logic [31:0] ID_WORD = {REVISION, DEV_ID, VENDOR, 1'b1};

    tap_state_e      state;
    logic [IR_W-1:0] active_op;
    logic            ir_serial;
    logic            dr_serial;
    insn_ctl_t       ctl;

    typedef struct packed {
        logic data;
        logic oe;
    } out_regs_t;

    out_regs_t out_d, out_q;

    tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    tap_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .state_i  (state),
        .tdi      (tdi),
        .active_o (active_op),
        .serial_o (ir_serial)
    );

    assign ctl = decode_op(active_op);

    tap_dr #(
        .CELLS   (CELLS),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .state_i  (state),
        .path_i   (ctl.path),
        .tdi      (tdi),
        .bsc_in   (bsc_in),
        .hold_o   (bsc_out),
        .serial_o (dr_serial)
    );

    always_comb begin
        out_d = out_q;
        out_d.oe = (state == ST_SHIFT_IR) || (state == ST_SHIFT_DR);
        if (state == ST_SHIFT_IR)
            out_d.data = ir_serial;
        else if (state == ST_SHIFT_DR)
            out_d.data = dr_serial;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)
            out_q <= '{data: 1'b0, oe: 1'b0};
        else
            out_q <= out_d;
    end

    assign tdo       = out_q.data;
    assign tdo_oe    = out_q.oe;
    assign ext_drive = ctl.ext_drive;
    assign hiz_force = ctl.hiz;

    assert_oe_shift_only_R10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == ((state == ST_SHIFT_IR) || (state == ST_SHIFT_DR)));

    assert_drive_modes_exclusive_R9: assert property (@(posedge tck) disable iff (!trst_n)
        !(ext_drive && hiz_force));

    assert_tdo_steady_at_rise_R10: assert property (@(negedge tck) disable iff (!trst_n)
        $stable(tdo) || $past(tdo_oe) || tdo_oe);

endmodule

// File: tb/scan_tap_bench.sv
module scan_tap_bench;
    localparam int unsigned CELLS = 8;
    localparam logic [15:0] DEV   = 16'h0312;

    logic             tck = 1'b0;
    logic             trst_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic             tdo, tdo_oe, ext_drive, hiz_force;
    logic [CELLS-1:0] bsc_in = '0;
    logic [CELLS-1:0] bsc_out;

    int n_checks = 0;
    int n_fail   = 0;
    int oe_bad   = 0;
    int edge_bad = 0;
    bit finished = 1'b0;

    always #10 tck = ~tck;

    scan_tap #(.CELLS(CELLS), .DEV_ID(DEV)) u_scan_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .bsc_in(bsc_in), .bsc_out(bsc_out), .ext_drive(ext_drive), .hiz_force(hiz_force)
    );

    function automatic logic [63:0] id_word();
        return {32'h0, 4'h0, DEV, 11'h033, 1'b1};
    endfunction

    function automatic logic [63:0] bypass_out(input logic [63:0] din, input int n);
        logic [63:0] r = '0;
        for (int i = 1; i < n; i++) r[i] = din[i-1];
        return r;
    endfunction

    function automatic logic [63:0] mask(input logic [63:0] v, input int n);
        return (n >= 64) ? v : (v & ((64'd1 << n) - 64'd1));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, input logic exp_oe, output logic so);
        @(negedge tck);
        #2;
        so = tdo;
        if (tdo_oe !== exp_oe) oe_bad++;
        tms = m;
        tdi = d;
        @(posedge tck);
        #2;
        if (exp_oe && tdo !== so) edge_bad++;
    endtask

    task automatic step(input logic m);
        logic unused;
        tick(m, 1'b0, 1'b0, unused);
    endtask

    task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            logic b;
            tick(i == n - 1, din[i], 1'b1, b);
            dout[i] = b;
        end
    endtask

    task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
        logic [63:0] o;
        step(1); step(1); step(0); step(0);
        shift_bits(4, {60'h0, op}, o);
        cap = o[3:0];
        step(1); step(0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        step(1); step(0); step(0);
        shift_bits(n, din, dout);
        step(1); step(0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0]  cap;
        logic [63:0] din, dout, pre;
        void'($urandom(32'h5eed_1149));

        // R1: reset state
        #45;
        check("R1 ext_drive in reset", {63'h0, ext_drive}, 64'h0);
        check("R1 hiz_force in reset", {63'h0, hiz_force}, 64'h0);
        check("R1 tdo_oe in reset", {63'h0, tdo_oe}, 64'h0);
        check("R1 bsc_out in reset", {56'h0, bsc_out}, 64'h0);
        @(negedge tck);
        trst_n = 1'b1;
        step(0);

        // R6: identification word selected by default
        scan_dr(32, {$urandom, $urandom}, dout);
        check("R6 id word after reset", mask(dout, 32), id_word());

        // R3 + R4: capture pattern, bypass path
        scan_ir(4'b1111, cap);
        check("R3 capture-IR pattern", {60'h0, cap}, 64'h1);
        for (int k = 0; k < 3; k++) begin
            din = {$urandom, $urandom};
            scan_dr(40, din, dout);
            check("R4 bypass delay", mask(dout, 40), bypass_out(din, 40));
        end

        // R5: reserved codes act as bypass
        for (int k = 0; k < 4; k++) begin
            logic [3:0] op;
            op = 4'(4 + ($urandom % 11));
            scan_ir(op, cap);
            din = {$urandom, $urandom};
            scan_dr(24, din, dout);
            check("R5 reserved code bypass", mask(dout, 24), bypass_out(din, 24));
            check("R5 reserved code no drive", {62'h0, ext_drive, hiz_force}, 64'h0);
        end

        // R7: sample / preload
        scan_ir(4'b0001, cap);
        check("R7 sample ext_drive low", {63'h0, ext_drive}, 64'h0);
        bsc_in = CELLS'($urandom);
        din = {$urandom, $urandom};
        scan_dr(CELLS, din, dout);
        check("R7 sampled inputs", mask(dout, CELLS), {56'h0, bsc_in});
        check("R7 preload to hold", {56'h0, bsc_out}, mask(din, CELLS));
        pre = {56'h0, bsc_out};

        // R11: bypass update leaves hold alone
        scan_ir(4'b1111, cap);
        scan_dr(16, {$urandom, $urandom}, dout);
        check("R11 hold unchanged by bypass update", {56'h0, bsc_out}, pre);
        check("R11 ext_drive stays low", {63'h0, ext_drive}, 64'h0);

        // R8: external test
        scan_ir(4'b0000, cap);
        check("R8 ext_drive high", {62'h0, ext_drive, hiz_force}, 64'h2);
        bsc_in = CELLS'($urandom);
        din = {$urandom, $urandom};
        scan_dr(CELLS, din, dout);
        check("R8 extest capture", mask(dout, CELLS), {56'h0, bsc_in});
        check("R8 extest update", {56'h0, bsc_out}, mask(din, CELLS));

        // R9: float outputs
        scan_ir(4'b0011, cap);
        check("R9 hiz_force high", {62'h0, ext_drive, hiz_force}, 64'h1);
        din = {$urandom, $urandom};
        scan_dr(20, din, dout);
        check("R9 highz path is bypass", mask(dout, 20), bypass_out(din, 20));

        // R2: five tms-high edges, then idle
        for (int k = 0; k < 5; k++) step(1);
        step(0);
        check("R2 tms escape clears hiz", {62'h0, ext_drive, hiz_force}, 64'h0);
        scan_dr(32, {$urandom, $urandom}, dout);
        check("R2 ident restored", mask(dout, 32), id_word());

        // R12: split identification scan around pause
        begin
            logic [63:0] a, b;
            step(1); step(0); step(0);
            shift_bits(8, 64'h0, a);
            step(0); step(0); step(1); step(0);
            shift_bits(24, 64'h0, b);
            step(1); step(0);
            check("R12 split scan", {32'h0, b[23:0], a[7:0]}, id_word());
        end

        // R10: output enable and edge discipline over the whole run
        check("R10 tdo_oe only in shift", oe_bad, 0);
        check("R10 tdo steady at rising edge", edge_bad, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule